// File: doc/BRIEF.md
# Interrupt Vector Ring Writer

This block turns interrupt events into fixed-size records in a circular buffer held in system memory. Each accepted event carries a source id, source data, a ring id, a VM id and an address-space id. The block packs them into a 128-bit record and sends that record to memory as four 32-bit words through a plain write port. Software sets the ring's location and length, reads records from the ring, and tells the block how far it has read by writing the read pointer. The block raises a level interrupt towards the host while unread records remain.

Both pointers count bytes, so each record moves the write pointer forward by 16. When the ring is full, the programmed policy decides what happens: the event input is either stalled, or the oldest record is overwritten and a flag is set in bit 0 of the write pointer. Software clears that flag with a write-one control bit. The block can also copy each new write pointer value to a separate memory address, so software can learn the pointer without a register read. Dropping either enable returns both pointers to zero.

Top module: `ivr_writer`

## Requirements
- R1: An accepted event is written as four words in four consecutive cycles, to byte addresses base*256 + wptr + 0, 4, 8 and 12, in that order. Word 0 holds the source id in bits [7:0]. Word 1 holds the 28-bit source data in bits [27:0]. Word 2 holds the ring id in [7:0], the VM id in [15:8] and the address-space id in [31:16]. Word 3 is zero, and every unused bit is zero.
- R2: Each written record advances the write pointer by 16 bytes, modulo the ring length. The ring length is 4*2^size bytes, where size sits in bits [5:1] of the ring control register (address 1) and is clamped to the range 2..PTR_W-2.
- R3: Events are accepted only while the interrupt-enable bit (main control, address 0, bit 0) and the ring-enable bit (ring control bit 0) are both set. ev_ready is low otherwise, and it stays low while a record is being written.
- R4: The ring is full when (wptr+16) mod length equals rptr. While the ring is full and overflow is disabled (ring control bit 6 clear), ev_ready stays low and nothing is written to memory.
- R5: If the ring is full at acceptance and overflow is enabled, the record is still written, the pointer advances, and bit 0 of the write pointer value (register address 4) is set.
- R6: Writing 1 to ring control bit 7 clears the overflow flag. This bit always reads back as 0.
- R7: When writeback is enabled (ring control bit 8), one extra memory write follows the fourth word. It carries the new write pointer value, flag included, to the 40-bit address {WBHI[7:0] (address 6), WBLO (address 5)}.
- R8: irq is high when interrupts are enabled, a record has been committed since the last read-pointer write (or re-arm applies), and entries are pending. Entries are pending when rptr differs from wptr or the overflow flag is set.
- R9: A write to the read pointer (address 3) drops irq when re-arm (main control bit 1) is clear. When re-arm is set, irq stays high after the write only if entries are still pending.
- R10: While either enable is clear, the read pointer, the write pointer and the overflow flag are held at zero.
- R11: After reset, ev_ready, irq and mem_we are low and all registers read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_valid | input | 1 | Event offered |
| ev_ready | output | 1 | Event accepted at this edge if valid |
| ev_src_id | input | 8 | Source id |
| ev_src_data | input | 28 | Source data |
| ev_ring_id | input | 8 | Ring id |
| ev_vm_id | input | 8 | VM id |
| ev_as_id | input | 16 | Address-space id |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from reg_addr) |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | 40 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| irq | output | 1 | Host interrupt request (level) |

## Verification
After the handshake edge, the four record words appear on the memory port in the next four cycles. The write pointer, the overflow flag and the interrupt change at the edge that ends the fourth word, and the writeback word, if enabled, takes the cycle after that. A register write takes effect at the edge on which it is presented, and the pointer clearing after a disable shows one edge later. The bench drives inputs and samples outputs on falling edges. It waits at least seven cycles after each event before it reads pointers, irq or the captured memory log, and it waits two cycles after each register write. It captures memory writes at rising edges into a log and compares their order, addresses and data.

// File: rtl/ivr_pkg.sv
package ivr_pkg;
    localparam int ENTRY_BYTES = 16;
    localparam int BASE_SHIFT  = 8;
    localparam int MEM_AW      = 32 + BASE_SHIFT;
    localparam int SIZE_W      = 5;
    localparam int SIZE_LSB    = 1;

    // ring control bit positions
    localparam int RB_EN      = 0;
    localparam int RB_OVF_EN  = 6;
    localparam int RB_OVF_CLR = 7;
    localparam int RB_WB_EN   = 8;
    // main control bit positions
    localparam int MC_INTR_EN = 0;
    localparam int MC_REARM   = 1;

    typedef enum logic [2:0] {
        RA_MAIN = 3'd0,
        RA_RING = 3'd1,
        RA_BASE = 3'd2,
        RA_RPTR = 3'd3,
        RA_WPTR = 3'd4,
        RA_WBLO = 3'd5,
        RA_WBHI = 3'd6
    } ivr_reg_e;

    typedef struct packed {
        logic [15:0] as_id;
        logic [7:0]  vm_id;
        logic [7:0]  ring_id;
        logic [27:0] src_data;
        logic [7:0]  src_id;
    } ivr_event_t;

    typedef struct packed {
        logic              intr_en;
        logic              rearm;
        logic              ring_en;
        logic              ovf_en;
        logic              wb_en;
        logic [SIZE_W-1:0] size;
        logic [31:0]       base;
        logic [MEM_AW-1:0] wb_addr;
    } ivr_cfg_t;

    typedef enum logic [1:0] {
        EM_IDLE = 2'd0,
        EM_WORD = 2'd1,
        EM_WB   = 2'd2
    } ivr_emit_e;

    function automatic logic [127:0] ivr_pack(input ivr_event_t e);
        logic [127:0] v;
        v          = '0;
        v[7:0]     = e.src_id;
        v[59:32]   = e.src_data;
        v[71:64]   = e.ring_id;
        v[79:72]   = e.vm_id;
        v[95:80]   = e.as_id;
        return v;
    endfunction
endpackage

// File: rtl/ivr_regs.sv
module ivr_regs
    import ivr_pkg::*;
#(
    parameter int PTR_W = 20
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             reg_wr,
    input  logic [2:0]       reg_addr,
    input  logic [31:0]      reg_wdata,
    output logic [31:0]      reg_rdata,
    input  logic [PTR_W-1:0] rptr,
    input  logic [PTR_W-1:0] wptr,
    input  logic             ovf_flag,
    output ivr_cfg_t         cfg,
    output logic             ovf_clr,
    output logic             rptr_wr,
    output logic [PTR_W-1:0] rptr_wdata
);
    logic              intr_en_q, rearm_q, ring_en_q, ovf_en_q, wb_en_q;
    logic [SIZE_W-1:0] size_q;
    logic [31:0]       base_q, wblo_q;
    logic [7:0]        wbhi_q;
    logic [31:0]       wptr_val;

    assign wptr_val = 32'(wptr) | 32'(ovf_flag);

    always_ff @(posedge clk) begin
        if (rst) begin
            intr_en_q <= 1'b0;
            rearm_q   <= 1'b0;
            ring_en_q <= 1'b0;
            ovf_en_q  <= 1'b0;
            wb_en_q   <= 1'b0;
            size_q    <= '0;
            base_q    <= '0;
            wblo_q    <= '0;
            wbhi_q    <= '0;
        end else if (reg_wr) begin
            case (reg_addr)
                RA_MAIN: begin
                    intr_en_q <= reg_wdata[MC_INTR_EN];
                    rearm_q   <= reg_wdata[MC_REARM];
                end
                RA_RING: begin
                    ring_en_q <= reg_wdata[RB_EN];
                    size_q    <= reg_wdata[SIZE_LSB +: SIZE_W];
                    ovf_en_q  <= reg_wdata[RB_OVF_EN];
                    wb_en_q   <= reg_wdata[RB_WB_EN];
                end
                RA_BASE: base_q <= reg_wdata;
                RA_WBLO: wblo_q <= reg_wdata;
                RA_WBHI: wbhi_q <= reg_wdata[7:0];
                default: ;
            endcase
        end
    end

    assign ovf_clr    = reg_wr && (reg_addr == RA_RING) && reg_wdata[RB_OVF_CLR];
    assign rptr_wr    = reg_wr && (reg_addr == RA_RPTR);
    assign rptr_wdata = reg_wdata[PTR_W-1:0];

    always_comb begin
        cfg.intr_en = intr_en_q;
        cfg.rearm   = rearm_q;
        cfg.ring_en = ring_en_q;
        cfg.ovf_en  = ovf_en_q;
        cfg.wb_en   = wb_en_q;
        cfg.size    = size_q;
        cfg.base    = base_q;
        cfg.wb_addr = {wbhi_q, wblo_q};
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            RA_MAIN: begin
                reg_rdata[MC_INTR_EN] = intr_en_q;
                reg_rdata[MC_REARM]   = rearm_q;
            end
            RA_RING: begin
                reg_rdata[RB_EN]                = ring_en_q;
                reg_rdata[SIZE_LSB +: SIZE_W]   = size_q;
                reg_rdata[RB_OVF_EN]            = ovf_en_q;
                reg_rdata[RB_WB_EN]             = wb_en_q;
            end
            RA_BASE: reg_rdata = base_q;
            RA_RPTR: reg_rdata = 32'(rptr);
            RA_WPTR: reg_rdata = wptr_val;
            RA_WBLO: reg_rdata = wblo_q;
            RA_WBHI: reg_rdata = 32'(wbhi_q);
            default: reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/ivr_ptr.sv
module ivr_ptr
    import ivr_pkg::*;
#(
    parameter int PTR_W = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enabled,
    input  logic              rearm,
    input  logic [SIZE_W-1:0] size,
    input  logic              commit,
    input  logic              commit_ovf,
    input  logic              ovf_clr,
    input  logic              rptr_wr,
    input  logic [PTR_W-1:0]  rptr_wdata,
    output logic [PTR_W-1:0]  wptr,
    output logic [PTR_W-1:0]  rptr,
    output logic              ovf_flag,
    output logic              full,
    output logic              irq
);
    localparam logic [SIZE_W-1:0] SZ_MIN = SIZE_W'(2);
    localparam logic [SIZE_W-1:0] SZ_MAX = SIZE_W'(PTR_W - 2);
    localparam logic [PTR_W-1:0]  ALIGN  = ~PTR_W'(ENTRY_BYTES - 1);

    logic [SIZE_W-1:0] sz_c;
    logic [PTR_W:0]    len;
    logic [PTR_W-1:0]  mask, wptr_adv;
    logic              armed, pending;

    assign sz_c     = (size < SZ_MIN) ? SZ_MIN : ((size > SZ_MAX) ? SZ_MAX : size);
    assign len      = (PTR_W+1)'(1) << (sz_c + SIZE_W'(2));
    assign mask     = len[PTR_W-1:0] - 1'b1;
    assign wptr_adv = (wptr + PTR_W'(ENTRY_BYTES)) & mask;
    assign full     = (wptr_adv == rptr);
    assign pending  = (wptr != rptr) || ovf_flag;
    assign irq      = enabled && armed && pending;

    always_ff @(posedge clk) begin
        if (rst || !enabled) begin
            wptr     <= '0;
            rptr     <= '0;
            ovf_flag <= 1'b0;
            armed    <= 1'b0;
        end else begin
            if (commit)
                wptr <= wptr_adv;
            if (commit && commit_ovf)
                ovf_flag <= 1'b1;
            else if (ovf_clr)
                ovf_flag <= 1'b0;
            if (rptr_wr)
                rptr <= rptr_wdata & mask & ALIGN;
            if (commit)
                armed <= 1'b1;
            else if (rptr_wr)
                armed <= rearm;
        end
    end

    assert_irq_pending_R8: assert property (@(posedge clk) disable iff (rst)
        irq |-> ((wptr != rptr) || ovf_flag));

    assert_disable_clears_R10: assert property (@(posedge clk) disable iff (rst)
        !enabled |=> (wptr == '0 && rptr == '0 && !ovf_flag));

    assert_flag_source_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(ovf_flag) |-> $past(commit && commit_ovf));

    assert_ptr_aligned_R2: assert property (@(posedge clk) disable iff (rst)
        (wptr[3:0] == 4'd0) && (rptr[3:0] == 4'd0));
endmodule

// File: rtl/ivr_emit.sv
module ivr_emit
    import ivr_pkg::*;
#(
    parameter int PTR_W = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enabled,
    input  logic              can_accept,
    input  logic              full,
    input  logic              wb_en,
    input  logic [31:0]       base,
    input  logic [MEM_AW-1:0] wb_addr,
    input  logic [PTR_W-1:0]  wptr,
    input  logic              ovf_flag,
    input  logic              ev_valid,
    input  ivr_event_t        ev,
    output logic              ev_ready,
    output logic              commit,
    output logic              commit_ovf,
    output logic              mem_we,
    output logic [MEM_AW-1:0] mem_addr,
    output logic [31:0]       mem_wdata
);
    ivr_emit_e    state;
    logic [1:0]   idx;
    logic [127:0] vec_q;
    logic         full_q;

    assign ev_ready   = (state == EM_IDLE) && can_accept;
    assign commit     = enabled && (state == EM_WORD) && (idx == 2'd3);
    assign commit_ovf = full_q;

    always_ff @(posedge clk) begin
        if (rst || !enabled) begin
            state  <= EM_IDLE;
            idx    <= '0;
            vec_q  <= '0;
            full_q <= 1'b0;
        end else begin
            case (state)
                EM_IDLE: if (ev_valid && ev_ready) begin
                    vec_q  <= ivr_pack(ev);
                    full_q <= full;
                    idx    <= '0;
                    state  <= EM_WORD;
                end
                EM_WORD: begin
                    idx <= idx + 2'd1;
                    if (idx == 2'd3)
                        state <= wb_en ? EM_WB : EM_IDLE;
                end
                EM_WB:   state <= EM_IDLE;
                default: state <= EM_IDLE;
            endcase
        end
    end

    always_comb begin
        mem_we    = enabled && (state == EM_WORD || state == EM_WB);
        mem_addr  = {base, 8'h00} + MEM_AW'(wptr) + MEM_AW'({idx, 2'b00});
        mem_wdata = vec_q[{idx, 5'd0} +: 32];
        if (state == EM_WB) begin
            mem_addr  = wb_addr;
            mem_wdata = 32'(wptr) | 32'(ovf_flag);
        end
    end

    assert_burst_continues_R1: assert property (@(posedge clk) disable iff (rst)
        (mem_we && state == EM_WORD && idx != 2'd3) |=> (mem_we || !enabled));

    assert_ready_needs_enable_R3: assert property (@(posedge clk) disable iff (rst)
        ev_ready |-> enabled);
endmodule

// File: rtl/ivr_writer.sv
module ivr_writer
    import ivr_pkg::*;
#(
    parameter int PTR_W = 20
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        ev_valid,
    output logic        ev_ready,
    input  logic [7:0]  ev_src_id,
    input  logic [27:0] ev_src_data,
    input  logic [7:0]  ev_ring_id,
    input  logic [7:0]  ev_vm_id,
    input  logic [15:0] ev_as_id,
    input  logic        reg_wr,
    input  logic [2:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        mem_we,
    output logic [39:0] mem_addr,
    output logic [31:0] mem_wdata,
    output logic        irq
);
    ivr_cfg_t         cfg;
    ivr_event_t       ev;
    logic             ovf_clr, rptr_wr, enabled, can_accept;
    logic             commit, commit_ovf, full, ovf_flag;
    logic [PTR_W-1:0] rptr_wdata, wptr, rptr;

    assign ev = '{as_id: ev_as_id, vm_id: ev_vm_id, ring_id: ev_ring_id,
                  src_data: ev_src_data, src_id: ev_src_id};
    assign enabled    = cfg.intr_en && cfg.ring_en;
    assign can_accept = enabled && (!full || cfg.ovf_en);

    ivr_regs #(.PTR_W(PTR_W)) u_regs (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rptr(rptr), .wptr(wptr),
        .ovf_flag(ovf_flag), .cfg(cfg), .ovf_clr(ovf_clr), .rptr_wr(rptr_wr),
        .rptr_wdata(rptr_wdata)
    );

    ivr_ptr #(.PTR_W(PTR_W)) u_ptr (
        .clk(clk), .rst(rst), .enabled(enabled), .rearm(cfg.rearm), .size(cfg.size),
        .commit(commit), .commit_ovf(commit_ovf), .ovf_clr(ovf_clr),
        .rptr_wr(rptr_wr), .rptr_wdata(rptr_wdata), .wptr(wptr), .rptr(rptr),
        .ovf_flag(ovf_flag), .full(full), .irq(irq)
    );

    ivr_emit #(.PTR_W(PTR_W)) u_emit (
        .clk(clk), .rst(rst), .enabled(enabled), .can_accept(can_accept), .full(full),
        .wb_en(cfg.wb_en), .base(cfg.base), .wb_addr(cfg.wb_addr), .wptr(wptr),
        .ovf_flag(ovf_flag), .ev_valid(ev_valid), .ev(ev), .ev_ready(ev_ready),
        .commit(commit), .commit_ovf(commit_ovf), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata)
    );

    assert_no_write_when_stalled_R4: assert property (@(posedge clk) disable iff (rst)
        ev_ready |-> (!full || cfg.ovf_en));
endmodule

// File: tb/tb_ivr_writer.sv
module tb_ivr_writer;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ev_valid = 1'b0;
    logic        ev_ready;
    logic [7:0]  ev_src_id = '0;
    logic [27:0] ev_src_data = '0;
    logic [7:0]  ev_ring_id = '0;
    logic [7:0]  ev_vm_id = '0;
    logic [15:0] ev_as_id = '0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mem_we;
    logic [39:0] mem_addr;
    logic [31:0] mem_wdata;
    logic        irq;

    int total = 0;
    int bad = 0;
    logic [39:0] log_a[$];
    logic [31:0] log_d[$];

    localparam logic [39:0] BASE_B = 40'h12300;
    localparam logic [31:0] RING_ON = 32'h0000_0009;  // enable, size 4 (64 bytes)

    always #2.5 clk = ~clk;

    ivr_writer dut (.*);

    always @(posedge clk) if (mem_we) begin
        log_a.push_back(mem_addr);
        log_d.push_back(mem_wdata);
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
        @(negedge clk);
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic send(input logic [7:0] s, input logic [27:0] dat, input logic [7:0] r,
                        input logic [7:0] v, input logic [15:0] p);
        @(negedge clk);
        log_a.delete(); log_d.delete();
        ev_src_id = s; ev_src_data = dat; ev_ring_id = r; ev_vm_id = v; ev_as_id = p;
        ev_valid = 1'b1;
        for (int i = 0; i < 20 && !ev_ready; i++) @(negedge clk);
        @(negedge clk);
        ev_valid = 1'b0;
        repeat (7) @(negedge clk);
    endtask

    task automatic t_reset;
        logic [31:0] d;
        @(negedge clk);
        chk("R11 ready", 64'(ev_ready), 0);
        chk("R11 irq", 64'(irq), 0);
        chk("R11 mem_we", 64'(mem_we), 0);
        for (int a = 0; a < 7; a++) begin
            rd(3'(a), d);
            chk("R11 reg", 64'(d), 0);
        end
    endtask

    task automatic t_basic;
        logic [31:0] d;
        wr(3'd2, 32'h123);
        wr(3'd1, RING_ON);
        chk("R3 ready needs intr enable", 64'(ev_ready), 0);
        wr(3'd0, 32'h1);
        chk("R3 ready when enabled", 64'(ev_ready), 1);
        send(8'hA5, 28'hABCDEF1, 8'h3C, 8'h7E, 16'hBEEF);
        chk("R1 count", 64'(log_a.size()), 4);
        if (log_a.size() == 4) begin
            chk("R1 a0", 64'(log_a[0]), 64'(BASE_B));
            chk("R1 a3", 64'(log_a[3]), 64'(BASE_B + 40'hC));
            chk("R1 w0", 64'(log_d[0]), 64'h000000A5);
            chk("R1 w1", 64'(log_d[1]), 64'h0ABCDEF1);
            chk("R1 w2", 64'(log_d[2]), 64'hBEEF7E3C);
            chk("R1 w3", 64'(log_d[3]), 64'h0);
        end
        rd(3'd4, d);
        chk("R2 wptr +16", 64'(d), 64'h10);
        chk("R8 irq on entry", 64'(irq), 1);
    endtask

    task automatic t_rearm;
        logic [31:0] d;
        wr(3'd3, 32'h0);
        chk("R9 no rearm drops irq", 64'(irq), 0);
        send(8'h01, 28'h0000002, 8'hFF, 8'h00, 16'h1234);
        if (log_a.size() == 4) begin
            chk("R1 a2 second", 64'(log_a[2]), 64'(BASE_B + 40'h18));
            chk("R1 w2 second", 64'(log_d[2]), 64'h123400FF);
        end
        rd(3'd4, d);
        chk("R2 wptr 0x20", 64'(d), 64'h20);
        chk("R8 irq again", 64'(irq), 1);
        wr(3'd0, 32'h3);
        wr(3'd3, 32'h10);
        chk("R9 rearm keeps irq while pending", 64'(irq), 1);
        wr(3'd3, 32'h20);
        chk("R9 rearm idle drops irq", 64'(irq), 0);
    endtask

    task automatic t_full;
        logic [31:0] d;
        send(8'h11, 28'h1, 8'h0, 8'h0, 16'h0);
        send(8'h22, 28'h2, 8'h0, 8'h0, 16'h0);
        if (log_a.size() == 4) chk("R2 write at 0x30", 64'(log_a[0]), 64'(BASE_B + 40'h30));
        rd(3'd4, d);
        chk("R2 wrap to 0", 64'(d), 64'h0);
        send(8'h33, 28'h3, 8'h0, 8'h0, 16'h0);
        rd(3'd4, d);
        chk("R2 wptr 0x10", 64'(d), 64'h10);
        @(negedge clk);
        log_a.delete(); log_d.delete();
        ev_valid = 1'b1;
        repeat (8) begin
            @(negedge clk);
            chk("R4 ready low when full", 64'(ev_ready), 0);
        end
        ev_valid = 1'b0;
        chk("R4 no memory writes", 64'(log_a.size()), 0);
        rd(3'd4, d);
        chk("R4 wptr unchanged", 64'(d), 64'h10);
    endtask

    task automatic t_ovf;
        logic [31:0] d;
        wr(3'd1, RING_ON | 32'h40);
        send(8'h44, 28'h4, 8'h0, 8'h0, 16'h0);
        if (log_a.size() == 4) chk("R5 overwrite addr", 64'(log_a[0]), 64'(BASE_B + 40'h10));
        rd(3'd4, d);
        chk("R5 flag in wptr", 64'(d), 64'h21);
        chk("R8 irq with flag", 64'(irq), 1);
        wr(3'd1, RING_ON | 32'hC0);
        rd(3'd4, d);
        chk("R6 flag cleared", 64'(d), 64'h20);
        rd(3'd1, d);
        chk("R6 clear bit reads 0", 64'(d), 64'h49);
        chk("R8 irq idle", 64'(irq), 0);
    endtask

    task automatic t_wb;
        wr(3'd5, 32'hCAFE0000);
        wr(3'd6, 32'h5A);
        wr(3'd1, RING_ON | 32'h140);
        send(8'h55, 28'h5, 8'h0, 8'h0, 16'h0);
        chk("R7 five writes", 64'(log_a.size()), 5);
        if (log_a.size() == 5) begin
            chk("R7 wb addr", 64'(log_a[4]), 64'h5ACAFE0000);
            chk("R7 wb data", 64'(log_d[4]), 64'h30);
        end
    endtask

    task automatic t_disable;
        logic [31:0] d;
        wr(3'd1, 32'h148);
        @(negedge clk);
        rd(3'd4, d);
        chk("R10 wptr zero", 64'(d), 0);
        rd(3'd3, d);
        chk("R10 rptr zero", 64'(d), 0);
        chk("R10 irq low", 64'(irq), 0);
        chk("R3 ready low ring off", 64'(ev_ready), 0);
        wr(3'd1, RING_ON);
        send(8'h66, 28'h6, 8'h0, 8'h0, 16'h0);
        if (log_a.size() == 4) chk("R10 restart at base", 64'(log_a[0]), 64'(BASE_B));
        rd(3'd4, d);
        chk("R10 wptr after restart", 64'(d), 64'h10);
    endtask

    initial begin
        #(5ns * 100000);
        bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset;
        t_basic;
        t_rearm;
        t_full;
        t_ovf;
        t_wb;
        t_disable;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule